// File: doc/BRIEF.md
# Fractional Codec Clock Generator

The block turns a 38.88 MHz master clock into the two clocks that a speech codec needs. The first is a bit clock with a nominal rate of 2.048 MHz. The second is a frame clock at 8 kHz. The master frequency is not an integer multiple of 2.048 MHz, so the bit clock comes from an integer divider that changes its length. Groups of 64 bit-clock cycles repeat continuously. In each group, the last cycle lasts 18 master periods and every other cycle lasts 19. A group therefore spans 1215 master clocks. The frame clock always spans exactly 256 bit-clock cycles, which is 4860 master clocks and exactly 8 kHz.

A single enable input switches the generator on and off, and the same enable is copied unchanged to an output pin. When the block is idle, both clocks are held low. An enable that arrives while the block is idle, including straight after reset, starts both clocks from the beginning of a frame within two master clocks. A disable takes effect only at the end of the frame in progress. This prevents any shortened pulse on either clock. Both outputs come straight from flip-flops.

Top module: `codec_clk_gen`

## Requirements
- R1: While reset is asserted, and at any time the generator is idle, `bitClk` and `frameClk` are both 0.
- R2: Every `bitClk` cycle starts with a high phase of exactly 9 master clocks.
- R3: Bit-clock cycles are indexed 0 to 255 within a frame. A cycle whose index modulo 64 equals 63 lasts 18 master clocks, with 9 of them low. Every other cycle lasts 19 master clocks, with 10 of them low.
- R4: One `frameClk` period contains exactly 256 `bitClk` cycles, which is 4860 master clocks.
- R5: `frameClk` is 1 during cycles 0 to 127 and 0 during cycles 128 to 255. Its rising and falling edges occur on the same master clock as a `bitClk` rising edge.
- R6: `enableOut` always equals `enableIn`, with no clock delay.
- R7: A running generator stops only after the last master clock of cycle 255. `enableIn` is sampled only on that master clock, so a low pulse on `enableIn` that ends before the frame ends has no effect on the clocks.
- R8: When `enableIn` is high on a rising master clock edge while the generator is idle, `bitClk` and `frameClk` both go high on the second rising edge after it. The new frame starts at cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 38.88 MHz master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enableIn | input | 1 | Generator enable |
| bitClk | output | 1 | Codec bit clock, nominally 2.048 MHz |
| frameClk | output | 1 | Codec frame clock, 8 kHz |
| enableOut | output | 1 | Copy of the enable input |

## Verification
The bench runs the generator through several complete frames and measures the high time and period of every bit-clock cycle. This shows whether the single short cycle falls at index 63 of each group or somewhere else. Each frame is entered in a different way: a start from reset, a frame that sees a short enable dropout, and a start after a disable. Comparing these frames shows whether the counters truly restart at zero or carry a stale phase. A disable raised in the middle of a frame checks that the frame completes before both clocks stop. The short dropout checks that enable is ignored away from the frame boundary.

// File: rtl/codec_clk_pkg.sv
package codec_clk_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic run;    // counters advance, clocks may toggle
    logic clear;  // hold counters at zero
  } ctlStrobe_t;
endpackage

// File: rtl/codec_clk_ctrl.sv
module codec_clk_ctrl
  import codec_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableIn,
  input  logic       frameEnd,
  output ctlStrobe_t ctl
);
  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (!running) begin
      running <= enableIn;           // start right away from idle
    end else if (frameEnd && !enableIn) begin
      running <= 1'b0;               // stop only at a frame boundary
    end
  end

  always_comb begin
    ctl.run   = running;
    ctl.clear = !running;
  end

  // R7: the generator only drops out of run on a frame boundary
  p_stop_at_frame_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(frameEnd));

  // R7: an enable seen while running keeps the generator running
  p_hold_while_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (running && enableIn) |=> running);
endmodule

// File: rtl/codec_clk_dp.sv
module codec_clk_dp
  import codec_clk_pkg::*;
#(
  parameter int LONG_LEN     = 19,
  parameter int SHORT_LEN    = 18,
  parameter int HIGH_LEN     = 9,
  parameter int GROUP_CYCLES = 64,
  parameter int FRAME_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output logic       frameEnd,
  output logic       bitClk,
  output logic       frameClk
);
  localparam int SUB_W = $clog2(LONG_LEN);
  localparam int CYC_W = $clog2(FRAME_CYCLES);
  localparam int GRP_W = $clog2(GROUP_CYCLES);
  localparam int HALF  = FRAME_CYCLES / 2;

  logic [SUB_W-1:0] subCnt;
  logic [SUB_W-1:0] subLastVal;
  logic [CYC_W-1:0] cycCnt;
  logic             groupLast;
  logic             subLast;
  logic             frameLast;

  always_comb begin
    groupLast  = (cycCnt[GRP_W-1:0] == GRP_W'(GROUP_CYCLES - 1));
    subLastVal = groupLast ? SUB_W'(SHORT_LEN - 1) : SUB_W'(LONG_LEN - 1);
    subLast    = (subCnt == subLastVal);
    frameLast  = (cycCnt == CYC_W'(FRAME_CYCLES - 1));
    frameEnd   = ctl.run && subLast && frameLast;
  end

  // Two-level counter: master clocks within a cycle, cycles within a frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
      cycCnt <= '0;
    end else if (ctl.clear) begin
      subCnt <= '0;
      cycCnt <= '0;
    end else if (ctl.run) begin
      if (subLast) begin
        subCnt <= '0;
        cycCnt <= frameLast ? '0 : cycCnt + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  // Registered outputs, no decode glitches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClk   <= 1'b0;
      frameClk <= 1'b0;
    end else begin
      bitClk   <= ctl.run && (subCnt < SUB_W'(HIGH_LEN));
      frameClk <= ctl.run && (cycCnt < CYC_W'(HALF));
    end
  end

  // R1: idle state produces quiet clocks on the next edge
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (!bitClk && !frameClk));

  // R8: each run starts from the beginning of a frame
  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.run) |-> (subCnt == '0 && cycCnt == '0));

  // R5: a frame clock rising edge is always a bit clock rising edge
  p_frame_rise_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameClk) |-> $rose(bitClk));

  // R5: a frame clock falling edge is also a bit clock rising edge
  p_frame_fall_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameClk) |-> $rose(bitClk));

  // R3: the cycle counter never exceeds the selected cycle length
  p_sub_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    subCnt <= subLastVal);
endmodule

// File: rtl/codec_clk_gen.sv
module codec_clk_gen
  import codec_clk_pkg::*;
#(
  parameter int LONG_LEN     = 19,
  parameter int SHORT_LEN    = 18,
  parameter int HIGH_LEN     = 9,
  parameter int GROUP_CYCLES = 64,
  parameter int FRAME_CYCLES = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic enableIn,
  output logic bitClk,
  output logic frameClk,
  output logic enableOut
);
  ctlStrobe_t ctl;
  logic       frameEnd;

  assign enableOut = enableIn;

  codec_clk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enableIn (enableIn),
    .frameEnd (frameEnd),
    .ctl      (ctl)
  );

  codec_clk_dp #(
    .LONG_LEN     (LONG_LEN),
    .SHORT_LEN    (SHORT_LEN),
    .HIGH_LEN     (HIGH_LEN),
    .GROUP_CYCLES (GROUP_CYCLES),
    .FRAME_CYCLES (FRAME_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .frameEnd (frameEnd),
    .bitClk   (bitClk),
    .frameClk (frameClk)
  );

  // R6: the enable copy never differs from the enable input
  p_enable_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    enableOut == enableIn);
endmodule

// File: tb/codec_clk_gen_tb.sv
module codec_clk_gen_tb;
  logic clk = 1'b0;
  logic rstN;
  logic enableIn;
  logic bitClk;
  logic frameClk;
  logic enableOut;
  int   tests = 0;
  int   fails = 0;

  always #5 clk = ~clk;

  codec_clk_gen u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .enableIn  (enableIn),
    .bitClk    (bitClk),
    .frameClk  (frameClk),
    .enableOut (enableOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Count samples until bitClk is seen high (bounded)
  task automatic waitRise(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bitClk && n < 100);
  endtask

  // Entry: sample where cycle 0 is first seen high.
  // Exit: first low sample of cycle 255. partSum covers cycles 0..254 plus the high of 255.
  task automatic measureFrame(output int partSum);
    partSum = 0;
    for (int k = 0; k < 256; k++) begin
      int h;
      int l;
      int expLen;
      chk("R5", $sformatf("frameClk at start of cycle %0d", k), int'(frameClk), (k < 128) ? 1 : 0);
      h = 1;
      @(negedge clk);
      while (bitClk && h < 40) begin
        h++;
        @(negedge clk);
      end
      chk("R2", $sformatf("high length of cycle %0d", k), h, 9);
      partSum += h;
      if (k < 255) begin
        l = 1;
        @(negedge clk);
        while (!bitClk && l < 40) begin
          l++;
          @(negedge clk);
        end
        expLen = ((k % 64) == 63) ? 18 : 19;
        chk("R3", $sformatf("period of cycle %0d", k), h + l, expLen);
        partSum += l;
      end
    end
  endtask

  // Cycle 255 ends and the next frame starts
  task automatic frameTailContinue(input int partSum);
    int l;
    l = 1;
    @(negedge clk);
    while (!bitClk && l < 40) begin
      l++;
      @(negedge clk);
    end
    chk("R3", "low length of short cycle 255", l, 9);
    chk("R4", "master clocks per frame", partSum + l, 4860);
    chk("R5", "frameClk rises with next frame", int'(frameClk), 1);
  endtask

  // Cycle 255 ends and the generator stays quiet
  task automatic frameTailStop();
    int l;
    int rises;
    int csHigh;
    l = 1;
    rises = 0;
    csHigh = 0;
    repeat (200) begin
      @(negedge clk);
      if (bitClk) rises++;
      if (frameClk) csHigh++;
      l++;
    end
    chk("R7", "bitClk high samples after disabled frame end", rises, 0);
    chk("R1", "frameClk high samples while idle", csHigh, 0);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    enableIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "bitClk in reset", int'(bitClk), 0);
    chk("R1", "frameClk in reset", int'(frameClk), 0);
    chk("R6", "enableOut in reset", int'(enableOut), 0);
    rstN = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (bitClk || frameClk) chk("R1", "clock active while disabled", 1, 0);
    end
    chk("R1", "bitClk idle after reset", int'(bitClk), 0);
  endtask

  task automatic t_start();
    int n;
    enableIn = 1'b1;
    #1;
    chk("R6", "enableOut follows enable high", int'(enableOut), 1);
    waitRise(n);
    chk("R8", "samples from enable to first bitClk high", n, 2);
    chk("R8", "frameClk high with first bitClk", int'(frameClk), 1);
  endtask

  task automatic t_runFrame();
    int s;
    measureFrame(s);
    frameTailContinue(s);
  endtask

  task automatic t_enableDropout();
    int s;
    fork
      measureFrame(s);
      begin
        repeat (700) @(negedge clk);
        enableIn = 1'b0;
        #1;
        chk("R6", "enableOut follows enable low", int'(enableOut), 0);
        repeat (6) @(negedge clk);
        enableIn = 1'b1;
      end
    join
    frameTailContinue(s);
  endtask

  task automatic t_disableMidFrame();
    int s;
    fork
      measureFrame(s);
      begin
        repeat (1500) @(negedge clk);
        enableIn = 1'b0;
      end
    join
    frameTailStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_start();
    t_runFrame();
    t_enableDropout();
    t_disableMidFrame();
    t_start();
    t_runFrame();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule